// File: doc/BRIEF.md
# Burst Write Address Sequencer

This block turns a single host command into a run of consecutive array writes. The host first programs a wide control word. It holds a starting array address, a target select that picks either the data array or the mask array, and a burst length. The host then pulses a start input. From then on, every cycle in which the host presents a valid data beat produces one write strobe toward the array. The strobe carries the current address and the target select.

The address field steps up by one on each beat and the length field steps down by one. Both fields change inside the control word itself, so after a burst the word holds the address just past the last written location and a length of zero. The host must reprogram the word before it starts another burst. A start with a length outside the legal range of 4 to 511 produces no writes and raises a sticky error flag. A register write attempted during a burst is refused and raises the same flag.

Top module: `bws_burst_seq`

## Requirements
- R1: After reset the readback word is all zeros, the block is not busy, the error flag is low, and no write strobe or done pulse is produced.
- R2: Control word layout: address in bits [15:0], target select in bit 16 (0 = data array, 1 = mask array), length in bits [27:19]. All other bits are reserved, are discarded on write and read back as zero.
- R3: A start while idle with a stored length from 4 to 511 makes the block busy on the next edge. While busy, each cycle with beat_valid high asserts arr_we in that same cycle, with arr_addr equal to the stored address and arr_sel_mask equal to the stored target select. Cycles without beat_valid produce no strobe.
- R4: Each accepted beat raises the stored address by exactly one at the clock edge that ends the beat. The address wraps from 16'hFFFF to 16'h0000.
- R5: Each accepted beat lowers the stored length by one. When a burst ends, the readback shows length 0 and the address equal to the start address plus the burst length. These values are not restored.
- R6: burst_done is high for exactly one cycle, together with the strobe of the final beat. After that the block is idle, and further beats produce no strobe and leave the control word unchanged.
- R7: A start with a stored length below 4 (including 0) issues no writes, leaves the block idle and the word unchanged, and sets burst_err. burst_err stays high until reset.
- R8: A register write while busy leaves the control word unchanged and sets burst_err. The running burst then continues from its current position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write enable |
| cfg_wdata | input | 72 | Control word write value |
| cfg_rdata | output | 72 | Control word readback, reserved bits zero |
| burst_start | input | 1 | Start a burst from the stored fields |
| beat_valid | input | 1 | Host presents a data beat this cycle |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | 16 | Array address for the current write |
| arr_sel_mask | output | 1 | Target select: 0 data array, 1 mask array |
| burst_done | output | 1 | Final beat of the burst |
| burst_busy | output | 1 | Burst in progress |
| burst_err | output | 1 | Sticky error: illegal length or write while busy |

## Verification
The bench goes after the ends of the length range. A burst of exactly 4 must run. A length of 3 or 0 must be refused, and a sequencer that compared against the wrong bound would either emit writes or miss the error. The full 511-beat burst checks that the length counter neither stops early nor runs past zero. A burst started at 16'hFFFE must wrap to zero, so a wrong address width would show up as a bad address. Gapped beats, beats sent after completion, and a register write in the middle of a burst expose three other faults: strobes on idle cycles, an extra write after done, or a reload that corrupts the running address.

// File: rtl/bws_pkg.sv
package bws_pkg;
    parameter int ADDR_W  = 16;
    parameter int LEN_W   = 9;
    parameter int REG_W   = 72;
    parameter int TGT_POS = 16;
    parameter int LEN_LSB = 19;
    parameter int MIN_LEN = 4;

    localparam int LEN_MSB = LEN_LSB + LEN_W - 1;

    typedef enum logic {
        TGT_DATA = 1'b0,
        TGT_MASK = 1'b1
    } tgt_e;

    typedef struct packed {
        tgt_e              tgt;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
    } burst_ctl_t;

    function automatic burst_ctl_t unpack_ctl(input logic [REG_W-1:0] w);
        burst_ctl_t c;
        c.addr = w[ADDR_W-1:0];
        c.tgt  = tgt_e'(w[TGT_POS]);
        c.len  = w[LEN_MSB:LEN_LSB];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctl(input burst_ctl_t c);
        logic [REG_W-1:0] w;
        w                  = '0;
        w[ADDR_W-1:0]      = c.addr;
        w[TGT_POS]         = c.tgt;
        w[LEN_MSB:LEN_LSB] = c.len;
        return w;
    endfunction

    function automatic logic len_legal(input logic [LEN_W-1:0] l);
        return (l >= LEN_W'(MIN_LEN));
    endfunction
endpackage

// File: rtl/bws_ctrl_reg.sv
module bws_ctrl_reg
    import bws_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  burst_ctl_t load_val,
    input  logic       adv,
    output burst_ctl_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (adv) begin
            q.addr <= q.addr + 1'b1;
            q.len  <= q.len - 1'b1;
        end
    end

    // R4: one step up per beat
    a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
        (adv && !load) |=> q.addr == ADDR_W'($past(q.addr) + 1'b1));

    // R5: one step down per beat
    a_r5_len_step: assert property (@(posedge clk) disable iff (rst)
        (adv && !load) |=> q.len == LEN_W'($past(q.len) - 1'b1));

    // R5: never advance past zero
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (rst)
        adv |-> q.len != '0);

    // R8: without load or beat the word holds
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        (!adv && !load) |=> $stable(q));
endmodule

// File: rtl/bws_seq.sv
module bws_seq (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic valid,
    input  logic reg_we,
    input  logic len_ok,
    input  logic last,
    output logic busy,
    output logic err,
    output logic beat,
    output logic done,
    output logic load_ok
);
    logic busy_q, err_q;

    assign busy    = busy_q;
    assign err     = err_q;
    assign beat    = busy_q & valid;
    assign done    = beat & last;
    assign load_ok = reg_we & ~busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (!busy_q && start && len_ok)
                busy_q <= 1'b1;
            else if (done)
                busy_q <= 1'b0;
            if ((!busy_q && start && !len_ok) || (reg_we && busy_q))
                err_q <= 1'b1;
        end
    end

    // R7: error flag is sticky
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R7: illegal start stays idle
    a_r7_bad_start_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && !len_ok) |=> !busy && err);

    // R6: done lasts a single cycle and ends the burst
    a_r6_done_once: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !busy);

    // R8: refused write flags an error
    a_r8_busy_write_err: assert property (@(posedge clk) disable iff (rst)
        (busy && reg_we) |=> err);
endmodule

// File: rtl/bws_burst_seq.sv
module bws_burst_seq
    import bws_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              burst_start,
    input  logic              beat_valid,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              arr_sel_mask,
    output logic              burst_done,
    output logic              burst_busy,
    output logic              burst_err
);
    burst_ctl_t ctl_q;
    logic       beat, load_ok, len_ok, last;

    assign len_ok = len_legal(ctl_q.len);
    assign last   = (ctl_q.len == LEN_W'(1));

    bws_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (burst_start),
        .valid   (beat_valid),
        .reg_we  (cfg_we),
        .len_ok  (len_ok),
        .last    (last),
        .busy    (burst_busy),
        .err     (burst_err),
        .beat    (beat),
        .done    (burst_done),
        .load_ok (load_ok)
    );

    bws_ctrl_reg u_reg (
        .clk      (clk),
        .rst      (rst),
        .load     (load_ok),
        .load_val (unpack_ctl(cfg_wdata)),
        .adv      (beat),
        .q        (ctl_q)
    );

    assign cfg_rdata    = pack_ctl(ctl_q);
    assign arr_we       = beat;
    assign arr_addr     = ctl_q.addr;
    assign arr_sel_mask = ctl_q.tgt;

    // R3: a strobe never appears outside a burst
    a_r3_strobe_in_burst: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> burst_busy && beat_valid);

    // R2: reserved bits read as zero
    a_r2_rsv_zero: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[REG_W-1:LEN_MSB+1] == '0 && cfg_rdata[LEN_LSB-1:TGT_POS+1] == '0);
endmodule

// File: tb/bws_burst_seq_tb_top.sv
`timescale 1ns/1ps
module bws_burst_seq_tb_top;
    import bws_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [REG_W-1:0]  cfg_wdata = '0;
    logic [REG_W-1:0]  cfg_rdata;
    logic              burst_start = 1'b0;
    logic              beat_valid = 1'b0;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_addr;
    logic              arr_sel_mask;
    logic              burst_done;
    logic              burst_busy;
    logic              burst_err;

    int n_chk = 0;
    int n_bad = 0;
    logic [17:0] exp_q[$];

    always #10 clk = ~clk;

    bws_burst_seq dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .burst_start(burst_start), .beat_valid(beat_valid),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_sel_mask(arr_sel_mask),
        .burst_done(burst_done), .burst_busy(burst_busy), .burst_err(burst_err)
    );

    function automatic logic [71:0] mk(input logic [15:0] a, input logic t, input logic [8:0] l);
        return {44'd0, l, 2'b00, t, a};
    endfunction

    task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pop expected writes as strobes appear
    always @(negedge clk) begin
        if (!rst) begin
            if (arr_we) begin
                n_chk++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R6/R7 actual=unexpected strobe addr %h expected=no strobe", arr_addr);
                end else begin
                    logic [17:0] e;
                    e = exp_q.pop_front();
                    if ({burst_done, arr_sel_mask, arr_addr} !== e) begin
                        n_bad++;
                        $display("FAIL R3/R4/R6 actual=%h expected=%h", {burst_done, arr_sel_mask, arr_addr}, e);
                    end
                end
            end else if (burst_done) begin
                n_chk++; n_bad++;
                $display("FAIL R6 actual=done without strobe expected=done with final strobe");
            end
        end
    end

    task automatic wreg(input logic [71:0] v);
        @(posedge clk); #1; cfg_we = 1'b1; cfg_wdata = v;
        @(posedge clk); #1; cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic pulse_start();
        @(posedge clk); #1; burst_start = 1'b1;
        @(posedge clk); #1; burst_start = 1'b0;
    endtask

    task automatic beats(input int n, input bit gap);
        int sent = 0;
        int cyc = 0;
        while (sent < n) begin
            @(posedge clk); #1;
            beat_valid = (!gap) || (cyc % 2 == 1);
            if (beat_valid) sent++;
            cyc++;
        end
        @(posedge clk); #1; beat_valid = 1'b0;
    endtask

    task automatic push(input logic [15:0] a, input logic t, input int n);
        for (int i = 0; i < n; i++)
            exp_q.push_back({(i == n - 1), t, 16'(a + 16'(i))});
    endtask

    task automatic run_burst(input logic [15:0] a, input logic t, input int n, input bit gap);
        wreg(mk(a, t, 9'(n)));
        push(a, t, n);
        pulse_start();
        check("R3 busy after legal start", {71'd0, burst_busy}, 72'd1);
        beats(n, gap);
        check("R6 idle after final beat", {71'd0, burst_busy}, 72'd0);
        check("R5 word consumed", cfg_rdata, mk(16'(a + 16'(n)), t, 9'd0));
        beats(3, 1'b0);
        check("R6 late beats leave word", cfg_rdata, mk(16'(a + 16'(n)), t, 9'd0));
        check("R3 all expected writes seen", 72'(exp_q.size()), 72'd0);
    endtask

    task automatic do_reset();
        @(posedge clk); #1; rst = 1'b1;
        repeat (2) @(posedge clk);
        #1; rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1 reset state
        check("R1 readback zero", cfg_rdata, 72'd0);
        check("R1 flags low", {69'd0, burst_busy, burst_err, arr_we}, 72'd0);

        // R2 layout and reserved bits
        wreg({72{1'b1}});
        check("R2 reserved bits dropped", cfg_rdata, mk(16'hFFFF, 1'b1, 9'h1FF));
        wreg(mk(16'h1234, 1'b0, 9'd77));
        check("R2 fields placed", cfg_rdata, mk(16'h1234, 1'b0, 9'd77));

        // R3 R4 R5 R6 minimum legal length, data array
        run_burst(16'h0100, 1'b0, 4, 1'b0);
        // gapped beats, mask array
        run_burst(16'h2000, 1'b1, 9, 1'b1);
        // R4 address wrap
        run_burst(16'hFFFE, 1'b0, 4, 1'b0);
        // maximum length
        run_burst(16'h1000, 1'b1, 511, 1'b0);
        check("R7 no error after legal bursts", {71'd0, burst_err}, 72'd0);

        // R8 write while busy
        wreg(mk(16'h0200, 1'b0, 9'd6));
        push(16'h0200, 1'b0, 6);
        pulse_start();
        beats(2, 1'b0);
        wreg(mk(16'h7777, 1'b1, 9'd9));
        check("R8 error set", {71'd0, burst_err}, 72'd1);
        check("R8 word unchanged", cfg_rdata, mk(16'h0202, 1'b0, 9'd4));
        beats(4, 1'b1);
        check("R8 burst finished", cfg_rdata, mk(16'h0206, 1'b0, 9'd0));
        check("R8 queue drained", 72'(exp_q.size()), 72'd0);

        // R7 length 3
        do_reset();
        wreg(mk(16'h0300, 1'b1, 9'd3));
        pulse_start();
        check("R7 len 3 idle", {71'd0, burst_busy}, 72'd0);
        check("R7 len 3 error", {71'd0, burst_err}, 72'd1);
        beats(3, 1'b0);
        check("R7 len 3 word unchanged", cfg_rdata, mk(16'h0300, 1'b1, 9'd3));
        repeat (3) @(posedge clk);
        #1;
        check("R7 error sticky", {71'd0, burst_err}, 72'd1);

        // R7 length 0, and reset clears error (R1)
        do_reset();
        @(negedge clk);
        check("R1 error cleared by reset", {71'd0, burst_err}, 72'd0);
        pulse_start();
        check("R7 len 0 idle", {71'd0, burst_busy}, 72'd0);
        check("R7 len 0 error", {71'd0, burst_err}, 72'd1);
        beats(2, 1'b0);
        check("R7 len 0 word unchanged", cfg_rdata, 72'd0);

        repeat (2) @(posedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule